// File: doc/BRIEF.md
# Two-Stage Programmable Watchdog Timer

This block is a watchdog timer that sits on a simple 32-bit register bus. Once software enables it, it counts down from one of sixteen power-of-two periods. Software must keep writing a fixed key word to the kick register to reload the count before it reaches zero. If the count does reach zero, the block responds in one of two ways, chosen by software:

- **Immediate mode:** it pulses the system reset output at once.
- **Two-stage mode:** it first raises an interrupt and starts a second period. It pulses the reset output only if that second period also runs out.

After the block is enabled, nothing short of a hardware reset of the block stops it.

The response is driven by four states:

- **ST_OFF:** the block is disabled.
- **ST_ARMED:** counting, with no interrupt pending.
- **ST_WARNED:** counting, with the interrupt pending.
- **ST_FIRING:** the reset pulse is in progress.

The named transitions are:

- **arm:** ST_OFF to ST_ARMED, when the enable bit is first written.
- **feed:** a kick in ST_ARMED, which stays in ST_ARMED and reloads the count.
- **warn:** an expiry in two-stage mode, ST_ARMED to ST_WARNED, with a reload.
- **bite:** an expiry in immediate mode from ST_ARMED, or any expiry in ST_WARNED, to ST_FIRING.
- **pardon:** a kick in ST_WARNED, to ST_ARMED with a reload.
- **acknowledge:** a read of the clear register in ST_WARNED, to ST_ARMED with no reload.
- **recover:** the end of the reset pulse, ST_FIRING to ST_ARMED with a reload.

Top module: `guard_timer`

## Requirements
- R1: After block reset, `wd_irq` and `wd_sys_rst` are 0, and both the control word (offset 0x00) and the live count (offset 0x08) read 0.
- R2: Control bit 0 is the enable. Once it is 1, writing 0 to it leaves it at 1 until block reset. Control bit 1 is the mode bit (0 = immediate, 1 = two-stage) and always reads back as written.
- R3: The timeout word at offset 0x04 holds two period indices. Bits [7:4] give the first-period index and bits [3:0] give the running index. Index i means 2^(BASE_EXP+i) clock cycles. The count loads period-1 on the edge that captures the enable write, and then drops by one per cycle. The first period after enable uses the first-period index.
- R4: Writing the full word 0x76 to offset 0x0C while enabled reloads the count from the running index. Any other value written there has no effect on the count. A kick while disabled has no effect.
- R5: In immediate mode, the count reaching 0 asserts `wd_sys_rst` on the next edge, with `wd_irq` staying 0.
- R6: In two-stage mode, the first expiry sets `wd_irq` and reloads from the running index. A second expiry with no kick in between asserts `wd_sys_rst` and keeps `wd_irq` high.
- R7: `wd_irq` (also bit 0 of offset 0x10) stays high until a valid kick clears it. Reading offset 0x10 does not clear it.
- R8: Reading offset 0x14 returns 0 and clears a pending interrupt without reloading the count. The following expiry then raises the interrupt again instead of resetting.
- R9: `wd_sys_rst` stays high for exactly RST_CYCLES cycles. After that the block is counting again from the running index, with `wd_irq` at 0.
- R10: A kick captured on the same edge as an expiry wins. The count reloads, and neither reset nor interrupt is raised.
- R11: Bit 6 of the parameter word at 0xF4 reads 1 when the fixed periods are built in. Offset 0xF8 returns VERSION and offset 0xFC returns TYPE_ID.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer and bus clock |
| rst_n | input | 1 | Active-low block reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| wd_irq | output | 1 | Pending first-stage interrupt |
| wd_sys_rst | output | 1 | System reset pulse request |

## Verification
A kick and an expiry can land on the same clock edge. A read of the clear register can also meet a running count. The bench places a correct-key write so that the edge capturing it is the edge on which the count sits at 0. It then checks that the reset output stays low and that the count reads back freshly reloaded on the next cycle. Every expected output level and read value is queued against the exact cycle number and compared by a monitor at the falling edge.

// File: rtl/gtm_pkg.sv
package gtm_pkg;

    localparam logic [7:0] OFF_CTRL   = 8'h00;
    localparam logic [7:0] OFF_RANGE  = 8'h04;
    localparam logic [7:0] OFF_COUNT  = 8'h08;
    localparam logic [7:0] OFF_KICK   = 8'h0C;
    localparam logic [7:0] OFF_STAT   = 8'h10;
    localparam logic [7:0] OFF_CLR    = 8'h14;
    localparam logic [7:0] OFF_PARAM1 = 8'hF4;
    localparam logic [7:0] OFF_VER    = 8'hF8;
    localparam logic [7:0] OFF_TYPE   = 8'hFC;

    localparam logic [31:0] KICK_KEY  = 32'h0000_0076;
    localparam int          NUM_IDX   = 16;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_ARMED,
        ST_WARNED,
        ST_FIRING
    } resp_state_e;

    typedef struct packed {
        logic [3:0] init_idx;
        logic [3:0] run_idx;
    } range_t;

endpackage

// File: rtl/gtm_regfile.sv
module gtm_regfile
    import gtm_pkg::*;
#(
    parameter int          CNT_W   = 31,
    parameter logic [31:0] VERSION = 32'h0001_0200,
    parameter logic [31:0] TYPE_ID = 32'hA5C3_0010,
    parameter bit          FIXED   = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [7:0]       bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    input  logic [CNT_W-1:0] count_i,
    input  logic             irq_i,
    output logic             en_o,
    output logic             mode_o,
    output range_t           range_o,
    output logic             start_o,
    output logic             kick_o,
    output logic             clr_o
);

    logic   en_q;
    logic   mode_q;
    range_t range_q;
    logic   wr_ctrl;
    logic   wr_range;
    logic   [31:0] param1_word;

    assign wr_ctrl  = bus_sel && bus_wr && (bus_addr == OFF_CTRL);
    assign wr_range = bus_sel && bus_wr && (bus_addr == OFF_RANGE);

    assign start_o = wr_ctrl && bus_wdata[0] && !en_q;
    assign kick_o  = bus_sel && bus_wr && (bus_addr == OFF_KICK) && (bus_wdata == KICK_KEY);
    assign clr_o   = bus_sel && !bus_wr && (bus_addr == OFF_CLR);

    generate
        if (FIXED) begin : g_fixed
            assign param1_word = 32'h0000_0040;
        end else begin : g_custom
            assign param1_word = 32'h0000_0000;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            mode_q  <= 1'b0;
            range_q <= '0;
        end else begin
            if (wr_ctrl) begin
                en_q   <= en_q | bus_wdata[0];
                mode_q <= bus_wdata[1];
            end
            if (wr_range) begin
                range_q <= bus_wdata[7:0];
            end
        end
    end

    always_comb begin
        bus_rdata = 32'h0;
        if (bus_sel && !bus_wr) begin
            unique case (bus_addr)
                OFF_CTRL:   bus_rdata = {30'h0, mode_q, en_q};
                OFF_RANGE:  bus_rdata = {24'h0, range_q};
                OFF_COUNT:  bus_rdata = 32'(count_i);
                OFF_STAT:   bus_rdata = {31'h0, irq_i};
                OFF_PARAM1: bus_rdata = param1_word;
                OFF_VER:    bus_rdata = VERSION;
                OFF_TYPE:   bus_rdata = TYPE_ID;
                default:    bus_rdata = 32'h0;
            endcase
        end
    end

    assign en_o    = en_q;
    assign mode_o  = mode_q;
    assign range_o = range_q;

    p_enable_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |=> en_q);

    p_mode_follows_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> (mode_q == $past(bus_wdata[1])));

endmodule

// File: rtl/gtm_counter.sv
module gtm_counter
    import gtm_pkg::*;
#(
    parameter int BASE_EXP = 16,
    parameter int CNT_W    = BASE_EXP + 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [3:0]       load_idx_i,
    input  logic             run_i,
    output logic [CNT_W-1:0] count_o,
    output logic             zero_o
);

    logic [CNT_W-1:0] period_tab [NUM_IDX];
    logic [CNT_W-1:0] count_q;

    for (genvar gi = 0; gi < NUM_IDX; gi++) begin : g_tab
        localparam logic [CNT_W:0] FULL = {{CNT_W{1'b0}}, 1'b1} << (BASE_EXP + gi);
        assign period_tab[gi] = CNT_W'(FULL - 1'b1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load_i) begin
            count_q <= period_tab[load_idx_i];
        end else if (run_i && (count_q != '0)) begin
            count_q <= count_q - 1'b1;
        end
    end

    assign count_o = count_q;
    assign zero_o  = (count_q == '0);

    p_count_steps_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !load_i && (count_q != '0)) |=> (count_q == $past(count_q) - 1'b1));

    p_idle_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !load_i) |=> $stable(count_q));

endmodule

// File: rtl/gtm_resp_fsm.sv
module gtm_resp_fsm
    import gtm_pkg::*;
#(
    parameter int RST_CYCLES = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       kick_i,
    input  logic       clr_i,
    input  logic       mode_i,
    input  logic       zero_i,
    input  range_t     range_i,
    output logic       load_o,
    output logic [3:0] load_idx_o,
    output logic       run_o,
    output logic       irq_o,
    output logic       sys_rst_o
);

    localparam int HOLD_W = $clog2(RST_CYCLES + 1);
    localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(RST_CYCLES - 1);

    resp_state_e     st_q;
    resp_state_e     st_d;
    logic [HOLD_W-1:0] hold_q;
    logic            irq_q;
    logic            rst_q;
    logic            hold_done;

    assign hold_done = (hold_q == '0);

    always_comb begin
        st_d       = st_q;
        load_o     = 1'b0;
        load_idx_o = range_i.run_idx;
        unique case (st_q)
            ST_OFF: begin
                if (start_i) begin
                    st_d       = ST_ARMED;
                    load_o     = 1'b1;
                    load_idx_o = range_i.init_idx;
                end
            end
            ST_ARMED: begin
                if (kick_i) begin
                    load_o = 1'b1;
                end else if (zero_i) begin
                    if (mode_i) begin
                        st_d   = ST_WARNED;
                        load_o = 1'b1;
                    end else begin
                        st_d = ST_FIRING;
                    end
                end
            end
            ST_WARNED: begin
                if (kick_i) begin
                    st_d   = ST_ARMED;
                    load_o = 1'b1;
                end else if (zero_i) begin
                    st_d = ST_FIRING;
                end else if (clr_i) begin
                    st_d = ST_ARMED;
                end
            end
            ST_FIRING: begin
                if (hold_done) begin
                    st_d   = ST_ARMED;
                    load_o = 1'b1;
                end
            end
            default: st_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_OFF;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
            irq_q  <= 1'b0;
            rst_q  <= 1'b0;
        end else begin
            rst_q <= (st_d == ST_FIRING);
            irq_q <= (st_d == ST_WARNED) || ((st_d == ST_FIRING) && irq_q);
            if ((st_q != ST_FIRING) && (st_d == ST_FIRING)) begin
                hold_q <= HOLD_LAST;
            end else if ((st_q == ST_FIRING) && !hold_done) begin
                hold_q <= hold_q - 1'b1;
            end
        end
    end

    assign run_o     = (st_q == ST_ARMED) || (st_q == ST_WARNED);
    assign irq_o     = irq_q;
    assign sys_rst_o = rst_q;

    p_kick_beats_expiry_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_ARMED) && kick_i && zero_i) |=> (!sys_rst_o && !irq_o && (st_q == ST_ARMED)));

    p_irq_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !kick_i && !clr_i && (st_q != ST_FIRING)) |=> irq_o);

    p_immediate_bite_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_ARMED) && !mode_i && zero_i && !kick_i) |=> (sys_rst_o && !irq_o));

    p_warn_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_ARMED) && mode_i && zero_i && !kick_i) |=> (irq_o && !sys_rst_o));

    p_recover_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_rst_o) |-> (!irq_o && run_o));

    generate
        if (RST_CYCLES > 1) begin : g_pulse_chk
            p_pulse_min_r9: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(sys_rst_o) |=> sys_rst_o);
        end
    endgenerate

endmodule

// File: rtl/guard_timer.sv
module guard_timer
    import gtm_pkg::*;
#(
    parameter int          BASE_EXP   = 16,
    parameter int          RST_CYCLES = 8,
    parameter logic [31:0] VERSION    = 32'h0001_0200,
    parameter logic [31:0] TYPE_ID    = 32'hA5C3_0010,
    parameter bit          FIXED      = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        wd_irq,
    output logic        wd_sys_rst
);

    localparam int CNT_W = BASE_EXP + 15;

    logic             en;
    logic             mode;
    range_t           range_w;
    logic             start;
    logic             kick;
    logic             clr;
    logic             load;
    logic [3:0]       load_idx;
    logic             run;
    logic [CNT_W-1:0] count;
    logic             zero;

    gtm_regfile #(
        .CNT_W   (CNT_W),
        .VERSION (VERSION),
        .TYPE_ID (TYPE_ID),
        .FIXED   (FIXED)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .count_i   (count),
        .irq_i     (wd_irq),
        .en_o      (en),
        .mode_o    (mode),
        .range_o   (range_w),
        .start_o   (start),
        .kick_o    (kick),
        .clr_o     (clr)
    );

    gtm_counter #(
        .BASE_EXP (BASE_EXP),
        .CNT_W    (CNT_W)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .load_idx_i (load_idx),
        .run_i      (run),
        .count_o    (count),
        .zero_o     (zero)
    );

    gtm_resp_fsm #(
        .RST_CYCLES (RST_CYCLES)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .kick_i     (kick),
        .clr_i      (clr),
        .mode_i     (mode),
        .zero_i     (zero),
        .range_i    (range_w),
        .load_o     (load),
        .load_idx_o (load_idx),
        .run_o      (run),
        .irq_o      (wd_irq),
        .sys_rst_o  (wd_sys_rst)
    );

    p_bite_needs_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_sys_rst || wd_irq) |-> en);

    p_no_run_before_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (count == '0));

endmodule

// File: tb/guard_timer_test.sv
module guard_timer_test;
    import gtm_pkg::*;

    localparam logic [31:0] T_VER  = 32'h0003_0100;
    localparam logic [31:0] T_TYPE = 32'h0000_5A5A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        wd_irq;
    logic        wd_sys_rst;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        int          at;
        int          kind;
        logic [31:0] val;
        string       tag;
    } item_t;

    item_t sb[$];
    item_t it;
    logic [31:0] act;

    guard_timer #(
        .BASE_EXP   (2),
        .RST_CYCLES (8),
        .VERSION    (T_VER),
        .TYPE_ID    (T_TYPE)
    ) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .wd_irq     (wd_irq),
        .wd_sys_rst (wd_sys_rst)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: pops queued expectations at the falling edge of their cycle
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            it = sb.pop_front();
            checks++;
            case (it.kind)
                0:       act = {31'h0, wd_sys_rst};
                1:       act = {31'h0, wd_irq};
                default: act = bus_rdata;
            endcase
            if (it.at != cyc || act !== it.val) begin
                errors++;
                $display("FAIL %s cycle %0d kind %0d actual %h expected %h",
                         it.tag, it.at, it.kind, act, it.val);
            end
        end
    end

    task automatic expect_at(input int at, input int kind, input logic [31:0] val, input string tag);
        item_t e;
        e.at = at; e.kind = kind; e.val = val; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        expect_at(cyc, 2, e, tag);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(posedge clk); #1;
        bus_sel = 1'b0;
    endtask

    task automatic wait_to(input int c);
        while (cyc < c) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic blk_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    initial begin
        int n;
        blk_reset();

        // S1: reset state, disabled kick, identity words
        expect_at(cyc, 0, 32'h0, "R1");
        expect_at(cyc, 1, 32'h0, "R1");
        rd(OFF_CTRL, 32'h0, "R1");
        rd(OFF_COUNT, 32'h0, "R1");
        wr(OFF_KICK, KICK_KEY);
        rd(OFF_COUNT, 32'h0, "R4 kick while disabled");
        expect_at(cyc, 0, 32'h0, "R4");
        rd(OFF_PARAM1, 32'h0000_0040, "R11");
        rd(OFF_VER, T_VER, "R11");
        rd(OFF_TYPE, T_TYPE, "R11");

        // S2: immediate mode, first period from init index, sticky enable, pulse
        blk_reset();
        wr(OFF_RANGE, 32'h10);
        n = cyc;
        wr(OFF_CTRL, 32'h1);
        rd(OFF_COUNT, 32'd7, "R3 first period");
        wr(OFF_CTRL, 32'h0);
        rd(OFF_CTRL, 32'h1, "R2 enable sticky");
        rd(OFF_COUNT, 32'd4, "R3 live count");
        expect_at(n + 8, 0, 32'h0, "R5");
        expect_at(n + 9, 0, 32'h1, "R5");
        expect_at(n + 9, 1, 32'h0, "R5");
        expect_at(n + 16, 0, 32'h1, "R9");
        expect_at(n + 17, 0, 32'h0, "R9");
        wait_to(n + 17);
        rd(OFF_COUNT, 32'd3, "R9 reload after pulse");

        // S3: key check, kick versus expiry on one edge
        blk_reset();
        wr(OFF_RANGE, 32'h11);
        n = cyc;
        wr(OFF_CTRL, 32'h1);
        wait_to(n + 3);
        wr(OFF_KICK, 32'h75);
        wait_to(n + 5);
        rd(OFF_COUNT, 32'd3, "R4 wrong key ignored");
        wait_to(n + 6);
        wr(OFF_KICK, KICK_KEY);
        rd(OFF_COUNT, 32'd7, "R4 kick reload");
        wait_to(n + 14);
        wr(OFF_KICK, KICK_KEY);
        expect_at(n + 15, 0, 32'h0, "R10");
        rd(OFF_COUNT, 32'd7, "R10 kick wins");
        expect_at(n + 22, 0, 32'h0, "R5");
        expect_at(n + 23, 0, 32'h1, "R5");
        expect_at(n + 31, 0, 32'h0, "R9");
        wait_to(n + 32);

        // S4: two-stage mode, status read, kick, clear read, final bite
        blk_reset();
        wr(OFF_RANGE, 32'h00);
        n = cyc;
        wr(OFF_CTRL, 32'h3);
        expect_at(n + 4, 1, 32'h0, "R6");
        expect_at(n + 5, 0, 32'h0, "R6");
        expect_at(n + 5, 1, 32'h1, "R6 first expiry");
        wait_to(n + 6);
        rd(OFF_STAT, 32'h1, "R7 status");
        expect_at(n + 7, 1, 32'h1, "R7 read keeps irq");
        wr(OFF_KICK, KICK_KEY);
        expect_at(n + 8, 1, 32'h0, "R7 kick clears");
        expect_at(n + 12, 1, 32'h1, "R6");
        wait_to(n + 12);
        rd(OFF_CLR, 32'h0, "R8 clear reads zero");
        expect_at(n + 13, 1, 32'h0, "R8");
        expect_at(n + 16, 0, 32'h0, "R8");
        expect_at(n + 16, 1, 32'h1, "R8 warn again");
        expect_at(n + 19, 0, 32'h0, "R6");
        expect_at(n + 20, 0, 32'h1, "R6 second expiry");
        expect_at(n + 20, 1, 32'h1, "R6");
        expect_at(n + 27, 0, 32'h1, "R9");
        expect_at(n + 28, 0, 32'h0, "R9");
        expect_at(n + 28, 1, 32'h0, "R9");
        wait_to(n + 30);

        if (sb.size() != 0) begin
            errors++;
            $display("FAIL scoreboard left %0d items actual %0d expected 0", sb.size(), sb.size());
        end
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule